// File: doc/BRIEF.md
# Transmit Descriptor Queue Manager

This block keeps track of transmit descriptor identifiers on their way through segmentation. The host hands over a descriptor by writing its identifier, together with the virtual circuit it belongs to, into a small pending queue. When the block has nothing more urgent to do, it takes the oldest pending entry and appends that identifier to the tail of the circuit's linked list. The lists live in per-circuit head and tail registers and in a next-pointer table indexed by descriptor identifier. An all-ones null code ends a list and marks an empty one.

The traffic scheduler names a circuit and receives that circuit's head descriptor, or a not-available flag when the list is empty. The order of service across circuits is set by the scheduler alone. When the buffer of a circuit's head descriptor is exhausted, the segmentation side raises an exhausted strobe for that circuit. The block then unlinks the head and pushes its identifier onto a release queue, where the host collects it. If the release queue is full, the strobe is held off and the list is left as it is.

All list work goes through one controller with four states. In `ST_IDLE` it picks one job per cycle, in this priority: an exhausted strobe (if the release queue has room), then a scheduler request, then a pending entry. Taking an exhausted strobe moves to `ST_UNLINK`, a request moves to `ST_REPLY`, and a pending entry moves to `ST_APPEND`. Each of the three busy states returns to `ST_IDLE` after one cycle.

Top module: `txd_queue_mgr`

## Requirements
- R1: A pending write is accepted on a clock edge where `pq_valid` and `pq_ready` are both 1. `pq_ready` is 0 exactly when PEND_DEPTH entries are waiting. Entries are moved to the lists only in cycles where no exhausted strobe is taken and `sch_req` is 0.
- R2: Identifiers submitted for the same circuit are served in submission order. Lists of different circuits do not affect one another.
- R3: A request is accepted on an edge where `sch_req` and `sch_ready` are both 1. In the next cycle `rsp_valid` is 1 for exactly one cycle, and `rsp_id` carries the current head of the requested circuit.
- R4: A request for a circuit whose list is empty answers with `rsp_none` = 1 and `rsp_id` = 0. `rsp_none` = 0 whenever a descriptor is returned.
- R5: An accepted exhausted strobe for a non-empty circuit removes its head. It pushes that identifier onto the release queue one cycle after acceptance, and the second entry becomes the new head.
- R6: Removing the only entry of a list leaves the circuit empty. A later append to that circuit becomes both its head and its tail.
- R7: While the release queue holds REL_DEPTH identifiers, `exh_ready` is 0 and the head of the named circuit stays unchanged. Scheduler requests are still served during this time.
- R8: An exhausted strobe for an empty circuit is accepted and has no effect: nothing is pushed onto the release queue.
- R9: When both are present, an exhausted strobe with room in the release queue is taken before a scheduler request, and a scheduler request is taken before a pending entry. The controller runs at most one list operation per cycle.
- R10: `rel_valid` is 1 exactly when the release queue is not empty. `rel_id` shows the oldest released identifier. `rel_pop` = 1 removes it, and identifiers leave in release order.
- R11: After reset every list is empty, `pq_ready` and `sch_ready` are 1, and `rel_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pq_valid | input | 1 | Host pending-queue write request |
| pq_vc | input | log2(NUM_VC) | Circuit of the submitted descriptor |
| pq_id | input | log2(NUM_DESC) | Submitted descriptor identifier |
| pq_ready | output | 1 | Pending queue has room |
| sch_req | input | 1 | Scheduler request |
| sch_vc | input | log2(NUM_VC) | Circuit selected by the scheduler |
| sch_ready | output | 1 | Request can be taken this cycle |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_id | output | log2(NUM_DESC) | Head descriptor of the selected circuit |
| rsp_none | output | 1 | Selected circuit has no descriptor |
| exh_valid | input | 1 | Buffer of the circuit's head descriptor is exhausted |
| exh_vc | input | log2(NUM_VC) | Circuit whose head is exhausted |
| exh_ready | output | 1 | Exhausted strobe can be taken |
| rel_valid | output | 1 | Release queue not empty |
| rel_id | output | log2(NUM_DESC) | Oldest released identifier |
| rel_pop | input | 1 | Host removes the oldest released identifier |

## Verification
Directed sequences come first. Requests to every empty circuit separate a correct not-available answer from a stale head. Interleaved submissions to two circuits show whether each list keeps arrival order and stays isolated. Removing a sole entry and then reusing the circuit shows whether the tail is cleaned up. Filling the release queue and then asserting a strobe shows whether back-pressure really freezes the list.

Two further directed cases cover arbitration. Holding a scheduler request while writing pending entries shows that appends are starved and that the pending queue reports full. A strobe and a request in the same cycle show the arbitration order. After these, a seeded random mix of submissions, requests, strobes and host pops is compared with a bench model of per-circuit lists and the release order.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_APPEND = 2'd1,
        ST_REPLY  = 2'd2,
        ST_UNLINK = 2'd3
    } txq_state_e;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cnt;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign pop_data = mem[rd_ptr];
    assign full     = (cnt == CW'(DEPTH));
    assign empty    = (cnt == '0);

    // R1 (pending instance) and R7 (release instance): no write into a full queue
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R10: no read from an empty queue
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/txq_link_table.sv
module txq_link_table #(
    parameter int NUM_VC   = 8,
    parameter int NUM_DESC = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        op_append,
    input  logic                        op_unlink,
    input  logic [$clog2(NUM_VC)-1:0]   op_vc,
    input  logic [$clog2(NUM_DESC)-1:0] op_id,
    output logic [$clog2(NUM_DESC):0]   cur_head
);
    localparam int DW = $clog2(NUM_DESC);
    localparam int PW = DW + 1;
    localparam logic [PW-1:0] NULL_PTR = {PW{1'b1}};

    logic [PW-1:0] head_q [NUM_VC];
    logic [PW-1:0] tail_q [NUM_VC];
    logic [PW-1:0] next_q [NUM_DESC];
    logic [PW-1:0] cur_tail;

    assign cur_head = head_q[op_vc];
    assign cur_tail = tail_q[op_vc];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VC; v++) begin
                head_q[v] <= NULL_PTR;
                tail_q[v] <= NULL_PTR;
            end
            for (int d = 0; d < NUM_DESC; d++) next_q[d] <= NULL_PTR;
        end else if (op_append) begin
            next_q[op_id] <= NULL_PTR;
            if (cur_head == NULL_PTR) head_q[op_vc] <= {1'b0, op_id};
            else                      next_q[cur_tail[DW-1:0]] <= {1'b0, op_id};
            tail_q[op_vc] <= {1'b0, op_id};
        end else if (op_unlink && cur_head != NULL_PTR) begin
            head_q[op_vc] <= next_q[cur_head[DW-1:0]];
            if (cur_head == cur_tail) tail_q[op_vc] <= NULL_PTR;
        end
    end

    // R6: head and tail of a circuit are null together
    assert_empty_consistent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_head == NULL_PTR) == (cur_tail == NULL_PTR));
    // R6: removing the sole entry leaves the circuit empty
    assert_last_unlink_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_unlink && cur_head != NULL_PTR && cur_head == cur_tail)
        |=> head_q[$past(op_vc)] == NULL_PTR);
    // R9: append and unlink never coincide
    assert_single_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_append && op_unlink));
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int NUM_VC   = 8,
    parameter int NUM_DESC = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pend_empty,
    input  logic [$clog2(NUM_VC)-1:0]   pend_vc,
    input  logic [$clog2(NUM_DESC)-1:0] pend_id,
    output logic                        pend_pop,
    input  logic                        sch_req,
    input  logic [$clog2(NUM_VC)-1:0]   sch_vc,
    output logic                        sch_ready,
    input  logic                        exh_valid,
    input  logic [$clog2(NUM_VC)-1:0]   exh_vc,
    output logic                        exh_ready,
    input  logic                        rel_full,
    output logic                        rel_push,
    output logic [$clog2(NUM_DESC)-1:0] rel_data,
    input  logic [$clog2(NUM_DESC):0]   cur_head,
    output logic                        op_append,
    output logic                        op_unlink,
    output logic [$clog2(NUM_VC)-1:0]   op_vc,
    output logic [$clog2(NUM_DESC)-1:0] op_id,
    output logic                        rsp_valid,
    output logic [$clog2(NUM_DESC)-1:0] rsp_id,
    output logic                        rsp_none
);
    localparam int VW = $clog2(NUM_VC);
    localparam int DW = $clog2(NUM_DESC);
    localparam int PW = DW + 1;
    localparam logic [PW-1:0] NULL_PTR = {PW{1'b1}};

    txq_state_e state_q, state_d;
    logic [VW-1:0] vc_q;
    logic [DW-1:0] id_q;
    logic take_exh, take_sch, take_pend, head_null;

    assign head_null = (cur_head == NULL_PTR);
    assign take_exh  = (state_q == ST_IDLE) && exh_valid && !rel_full;
    assign take_sch  = (state_q == ST_IDLE) && sch_req && !take_exh;
    assign take_pend = (state_q == ST_IDLE) && !pend_empty && !take_exh && !sch_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if      (take_exh)  state_d = ST_UNLINK;
                else if (take_sch)  state_d = ST_REPLY;
                else if (take_pend) state_d = ST_APPEND;
            end
            ST_APPEND: state_d = ST_IDLE;
            ST_REPLY:  state_d = ST_IDLE;
            ST_UNLINK: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vc_q    <= '0;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                vc_q <= take_exh ? exh_vc : (take_sch ? sch_vc : pend_vc);
                id_q <= pend_id;
            end
        end
    end

    always_comb begin
        exh_ready = 1'b0;
        sch_ready = 1'b0;
        pend_pop  = 1'b0;
        op_append = 1'b0;
        op_unlink = 1'b0;
        rel_push  = 1'b0;
        rsp_valid = 1'b0;
        rsp_none  = 1'b0;
        rsp_id    = '0;
        unique case (state_q)
            ST_IDLE: begin
                exh_ready = !rel_full;
                sch_ready = !(exh_valid && !rel_full);
                pend_pop  = take_pend;
            end
            ST_APPEND: op_append = 1'b1;
            ST_REPLY: begin
                rsp_valid = 1'b1;
                rsp_none  = head_null;
                rsp_id    = head_null ? '0 : cur_head[DW-1:0];
            end
            ST_UNLINK: begin
                op_unlink = 1'b1;
                rel_push  = !head_null;
            end
        endcase
    end

    assign op_vc    = vc_q;
    assign op_id    = id_q;
    assign rel_data = cur_head[DW-1:0];

    // R3: a response follows exactly one accepted request
    assert_rsp_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(sch_req && sch_ready));
    // R9: at most one job taken per cycle
    assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pend_pop, sch_req && sch_ready, exh_valid && exh_ready}));
    // R7: a release push never meets a full queue
    assert_release_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_push |-> !rel_full);
    // R4: not-available only with a response
    assert_none_in_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_none |-> rsp_valid);
endmodule

// File: rtl/txd_queue_mgr.sv
module txd_queue_mgr #(
    parameter int NUM_VC     = 8,
    parameter int NUM_DESC   = 16,
    parameter int PEND_DEPTH = 4,
    parameter int REL_DEPTH  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pq_valid,
    input  logic [$clog2(NUM_VC)-1:0]   pq_vc,
    input  logic [$clog2(NUM_DESC)-1:0] pq_id,
    output logic                        pq_ready,
    input  logic                        sch_req,
    input  logic [$clog2(NUM_VC)-1:0]   sch_vc,
    output logic                        sch_ready,
    output logic                        rsp_valid,
    output logic [$clog2(NUM_DESC)-1:0] rsp_id,
    output logic                        rsp_none,
    input  logic                        exh_valid,
    input  logic [$clog2(NUM_VC)-1:0]   exh_vc,
    output logic                        exh_ready,
    output logic                        rel_valid,
    output logic [$clog2(NUM_DESC)-1:0] rel_id,
    input  logic                        rel_pop
);
    localparam int VW = $clog2(NUM_VC);
    localparam int DW = $clog2(NUM_DESC);
    localparam int PW = DW + 1;

    logic          pend_full, pend_empty, pend_pop;
    logic [VW+DW-1:0] pend_data;
    logic          rel_full, rel_empty, rel_push;
    logic [DW-1:0] rel_data;
    logic [PW-1:0] cur_head;
    logic          op_append, op_unlink;
    logic [VW-1:0] op_vc;
    logic [DW-1:0] op_id;

    assign pq_ready  = !pend_full;
    assign rel_valid = !rel_empty;

    txq_fifo #(.WIDTH(VW + DW), .DEPTH(PEND_DEPTH)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (pq_valid && !pend_full),
        .push_data ({pq_vc, pq_id}),
        .pop       (pend_pop),
        .pop_data  (pend_data),
        .full      (pend_full),
        .empty     (pend_empty)
    );

    txq_fifo #(.WIDTH(DW), .DEPTH(REL_DEPTH)) u_rel (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rel_push),
        .push_data (rel_data),
        .pop       (rel_pop && !rel_empty),
        .pop_data  (rel_id),
        .full      (rel_full),
        .empty     (rel_empty)
    );

    txq_link_table #(.NUM_VC(NUM_VC), .NUM_DESC(NUM_DESC)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_append (op_append),
        .op_unlink (op_unlink),
        .op_vc     (op_vc),
        .op_id     (op_id),
        .cur_head  (cur_head)
    );

    txq_ctrl #(.NUM_VC(NUM_VC), .NUM_DESC(NUM_DESC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_empty (pend_empty),
        .pend_vc    (pend_data[VW+DW-1:DW]),
        .pend_id    (pend_data[DW-1:0]),
        .pend_pop   (pend_pop),
        .sch_req    (sch_req),
        .sch_vc     (sch_vc),
        .sch_ready  (sch_ready),
        .exh_valid  (exh_valid),
        .exh_vc     (exh_vc),
        .exh_ready  (exh_ready),
        .rel_full   (rel_full),
        .rel_push   (rel_push),
        .rel_data   (rel_data),
        .cur_head   (cur_head),
        .op_append  (op_append),
        .op_unlink  (op_unlink),
        .op_vc      (op_vc),
        .op_id      (op_id),
        .rsp_valid  (rsp_valid),
        .rsp_id     (rsp_id),
        .rsp_none   (rsp_none)
    );
endmodule

// File: tb/tb_txd_queue_mgr.sv
module tb_txd_queue_mgr;
    localparam int NV = 8;
    localparam int ND = 16;
    localparam int RD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pq_valid = 1'b0;
    logic [2:0] pq_vc = '0;
    logic [3:0] pq_id = '0;
    logic pq_ready;
    logic sch_req = 1'b0;
    logic [2:0] sch_vc = '0;
    logic sch_ready, rsp_valid, rsp_none;
    logic [3:0] rsp_id;
    logic exh_valid = 1'b0;
    logic [2:0] exh_vc = '0;
    logic exh_ready, rel_valid;
    logic [3:0] rel_id;
    logic rel_pop = 1'b0;

    int total = 0;
    int fails = 0;
    int mq [NV][ND];
    int mcnt [NV];
    int rq [RD];
    int rcnt = 0;
    bit used [ND];

    always #4 clk = ~clk;

    txd_queue_mgr dut (
        .clk(clk), .rst_n(rst_n),
        .pq_valid(pq_valid), .pq_vc(pq_vc), .pq_id(pq_id), .pq_ready(pq_ready),
        .sch_req(sch_req), .sch_vc(sch_vc), .sch_ready(sch_ready),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_none(rsp_none),
        .exh_valid(exh_valid), .exh_vc(exh_vc), .exh_ready(exh_ready),
        .rel_valid(rel_valid), .rel_id(rel_id), .rel_pop(rel_pop)
    );

    function automatic int exp_none(int vc);
        return (mcnt[vc] == 0) ? 1 : 0;
    endfunction

    function automatic int exp_head(int vc);
        return (mcnt[vc] == 0) ? 0 : mq[vc][0];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic submit(input int vc, input int id);
        pq_valid = 1'b1; pq_vc = 3'(vc); pq_id = 4'(id);
        #1;
        while (!pq_ready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        pq_valid = 1'b0;
        mq[vc][mcnt[vc]] = id; mcnt[vc]++; used[id] = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic sched(input int vc, input string req);
        sch_req = 1'b1; sch_vc = 3'(vc);
        #1;
        while (!sch_ready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        sch_req = 1'b0;
        #1;
        chk({req, " R3 rsp_valid"}, int'(rsp_valid), 1);
        chk({req, " R4 rsp_none"}, int'(rsp_none), exp_none(vc));
        chk({req, " R2 rsp_id"}, int'(rsp_id), exp_head(vc));
        @(negedge clk);
    endtask

    task automatic model_unlink(input int vc);
        if (mcnt[vc] > 0) begin
            rq[rcnt] = mq[vc][0]; rcnt++;
            for (int k = 0; k < ND - 1; k++) mq[vc][k] = mq[vc][k+1];
            mcnt[vc]--;
        end
    endtask

    task automatic exhaust(input int vc, input string req);
        exh_valid = 1'b1; exh_vc = 3'(vc);
        #1;
        while (!exh_ready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        exh_valid = 1'b0;
        model_unlink(vc);
        @(negedge clk);
        #1;
        chk({req, " R10 rel_valid"}, int'(rel_valid), (rcnt > 0) ? 1 : 0);
    endtask

    task automatic pop_rel(input string req);
        #1;
        chk({req, " R10 rel_valid"}, int'(rel_valid), (rcnt > 0) ? 1 : 0);
        if (rcnt > 0) begin
            chk({req, " R5 rel_id"}, int'(rel_id), rq[0]);
            used[rq[0]] = 1'b0;
            for (int k = 0; k < RD - 1; k++) rq[k] = rq[k+1];
            rcnt--;
            rel_pop = 1'b1;
            @(posedge clk); @(negedge clk);
            rel_pop = 1'b0;
        end else begin
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int v = 0; v < NV; v++) mcnt[v] = 0;
        for (int d = 0; d < ND; d++) used[d] = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R11 pq_ready", int'(pq_ready), 1);
        chk("R11 sch_ready", int'(sch_ready), 1);
        chk("R11 rel_valid", int'(rel_valid), 0);
        chk("R11 rsp_valid", int'(rsp_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) sched(v, "R11 R4 empty after reset");

        // R2: order and isolation across two circuits
        submit(2, 5); submit(5, 12); submit(2, 9); submit(2, 1);
        sched(2, "R2 first");
        sched(5, "R2 other vc");
        exhaust(2, "R5 unlink");
        sched(2, "R5 new head");
        pop_rel("R5 release");

        // R6: sole entry removed, then circuit reused
        exhaust(5, "R6 last");
        sched(5, "R6 now empty");
        pop_rel("R6 release");
        submit(5, 3);
        sched(5, "R6 reuse");

        // R8: strobe on empty circuit pushes nothing
        exhaust(7, "R8 empty vc");
        #1; chk("R8 rel_valid stays low", int'(rel_valid), 0);
        @(negedge clk);

        // R9: strobe beats simultaneous request
        exh_valid = 1'b1; exh_vc = 3'd2; sch_req = 1'b1; sch_vc = 3'd2;
        #1;
        chk("R9 exh_ready", int'(exh_ready), 1);
        chk("R9 sch_ready", int'(sch_ready), 0);
        @(posedge clk); @(negedge clk);
        exh_valid = 1'b0;
        model_unlink(2);
        #1;
        while (!sch_ready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        sch_req = 1'b0;
        #1;
        chk("R9 rsp after unlink", int'(rsp_id), exp_head(2));
        @(negedge clk);
        pop_rel("R9 release");

        // R7: release full blocks strobe, list untouched
        submit(0, 0); submit(0, 2); submit(0, 4); submit(0, 6);
        for (int k = 0; k < RD; k++) exhaust(0, "R7 fill");
        exh_valid = 1'b1; exh_vc = 3'd2;
        for (int k = 0; k < 3; k++) begin
            #1; chk("R7 exh_ready low", int'(exh_ready), 0);
            @(negedge clk);
        end
        exh_valid = 1'b0;
        sched(2, "R7 head unchanged");
        for (int k = 0; k < RD; k++) pop_rel("R10 order");
        pop_rel("R10 drained");

        // R1: request held starves appends, pending fills
        sch_req = 1'b1; sch_vc = 3'd7;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            pq_valid = 1'b1; pq_vc = 3'd6; pq_id = 4'(7 + k + (k > 1 ? 1 : 0));
            #1; chk("R1 pq_ready while room", int'(pq_ready), 1);
            @(posedge clk); @(negedge clk);
        end
        pq_valid = 1'b0;
        #1; chk("R1 pq_ready full", int'(pq_ready), 0);
        for (int k = 0; k < 4; k++) begin
            mq[6][mcnt[6]] = 7 + k + (k > 1 ? 1 : 0); mcnt[6]++;
            used[7 + k + (k > 1 ? 1 : 0)] = 1'b1;
        end
        @(negedge clk);
        sch_req = 1'b0;
        repeat (12) @(negedge clk);
        #1; chk("R1 pq_ready drained", int'(pq_ready), 1);
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            sched(6, "R2 drained order");
            exhaust(6, "R2 drained order");
            pop_rel("R2 drained order");
        end

        // Random phase
        void'($urandom(32'd20240611));
        for (int it = 0; it < 400; it++) begin
            int op, vc, id;
            op = int'($urandom % 4);
            vc = int'($urandom % NV);
            case (op)
                0: begin
                    id = -1;
                    for (int t = 0; t < ND; t++) begin
                        int c;
                        c = int'(($urandom + t) % ND);
                        if (!used[c] && id < 0) id = c;
                    end
                    if (id >= 0) submit(vc, id);
                end
                1: sched(vc, "R2 random");
                2: if (rcnt < RD) exhaust(vc, "R5 random");
                default: pop_rel("R10 random");
            endcase
        end
        finish_run();
    end
endmodule